// File: doc/BRIEF.md
# Configurable UART with Loopback Routing

This block is a full-duplex asynchronous serial transmitter and receiver that share one programmable baud generator. A 13-bit divisor sets the bit rate to the bus clock divided by sixteen times the divisor. A divisor of zero stops the generator. The transmitter takes a parallel word through a valid/ready handshake and sends it as a serial frame. The receiver oversamples its input sixteen times per bit and hands each decoded word over with a one-cycle strobe and a framing-error flag. Frames carry either 8 or 9 data bits.

Two control inputs choose the receiver's source. The first mode is two separate pins. The second is an internal path from the transmitter output, which leaves the RxD pin unused. The third is a single shared wire: the TxD pad carries transmitted bits and also feeds the receiver. In the shared-wire mode the TxD driver is enabled only while a frame is going out, so another device can drive the wire when the transmitter is idle. The level on the TxD pad comes back into the block through a sense input, and the receiver reads that input in the shared-wire mode.

Top module: `uartl_top`

## Requirements
- R1: For a divisor N from 1 to 8191, each transmitted bit lasts exactly 16×N bus clock cycles once the frame is under way.
- R2: While the divisor is 0, `tx_ready` is low, `txd_o` is high and the receiver delivers no word. Once a nonzero divisor is restored, both sides work again.
- R3: With `cfg_nine` = 0, a frame is one low start bit, then `tx_data[7:0]` least significant bit first, then one high stop bit. `tx_data[8]` is not sent, received words have `rx_data[8]` = 0, and the idle line is high.
- R4: With `cfg_nine` = 1, `tx_data[8]` is sent as an extra data bit between bit 7 and the stop bit, and the receiver returns it in `rx_data[8]`.
- R5: With `cfg_loop` = 0, the receiver reads `rxd_i` and `txd_oe` stays high.
- R6: With `cfg_loop` = 1 and `cfg_src` = 0, the receiver reads the transmitter output internally, `rxd_i` has no effect, and `txd_oe` stays high.
- R7: With `cfg_loop` = 1 and `cfg_src` = 1, the receiver reads `txd_pad_i` and `rxd_i` has no effect. `txd_oe` is high from the cycle the start bit begins until the stop bit ends, and low whenever the transmitter is idle.
- R8: With `cfg_loop` = 0, the value of `cfg_src` has no effect on routing or on `txd_oe`.
- R9: A stop bit whose majority sample is low sets `rx_ferr` = 1, and the word is still delivered. A high stop bit gives `rx_ferr` = 0.
- R10: `tx_ready` is high only when the transmitter is idle and the divisor is nonzero. A word is taken on a cycle with `tx_valid` and `tx_ready` both high, and `tx_ready` is low on the following cycle.
- R11: Each bit is decided by a majority vote of its 7th, 8th and 9th oversamples. A low pulse shorter than the start-bit vote point is rejected and produces no word.
- R12: `rx_valid` is high for exactly one cycle per received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 13 | Baud divisor; 0 stops the generator |
| cfg_loop | input | 1 | Loop routing enable |
| cfg_src | input | 1 | With loop enabled: 0 internal path, 1 shared wire |
| cfg_nine | input | 1 | 1 selects 9 data bits per frame |
| tx_data | input | 9 | Word to transmit; bit 8 is used only in 9-bit mode |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmitter can take a word |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | One-cycle strobe marking a new word |
| rx_ferr | output | 1 | Framing error for the word marked by `rx_valid` |
| rxd_i | input | 1 | Receive pin |
| txd_pad_i | input | 1 | Sensed level of the TxD pad |
| txd_o | output | 1 | Transmit pin data |
| txd_oe | output | 1 | Transmit pin driver enable |

## Verification
A transmitter stuck in a wrong frame state shows up on `txd_o` as a bit of the wrong length or a missing stop bit within one character time. A receiver in the wrong state returns a word with the wrong value or the wrong flag at the mid-stop sample, or returns a word that was never sent. Every word is sent through one of the three routes and checked against a queue of expected words. A wrong source selection therefore appears as a missing, extra or corrupted word before the next frame starts. Driver-enable faults show up within one cycle of the transmitter leaving or entering idle. Faults in the divisor-zero handling show up as movement on `txd_o` or as a stray strobe while the generator is stopped.

// File: rtl/uartl_pkg.sv
package uartl_pkg;

    localparam int unsigned OVS   = 16;
    localparam int unsigned OVS_W = $clog2(OVS);

    // oversample indices (0-based) of the three votes: 7th, 8th, 9th samples
    localparam int unsigned SMP_A = 6;
    localparam int unsigned SMP_B = 7;
    localparam int unsigned SMP_C = 8;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_NINTH,
        FR_STOP
    } frame_e;

    typedef enum logic [1:0] {
        RT_PINS,
        RT_INTERNAL,
        RT_SHARED
    } route_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uartl_baud.sv
module uartl_baud #(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } baud_s;

    baud_s q, d;

    always_comb begin
        d = q;
        if (div == '0) begin
            d.cnt  = '0;
            d.tick = 1'b0;
        end else if (q.cnt >= div - 1'b1) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

endmodule

// File: rtl/uartl_tx.sv
module uartl_tx
    import uartl_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        tick,
    input  logic        nine,
    input  logic [DW:0] wr_word,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic        line,
    output logic        busy
);

    localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        frame_e           st;
        logic [OVS_W-1:0] sub;
        logic [IW-1:0]    idx;
        logic [DW:0]      sh;
        logic             line;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d.st   = FR_IDLE;
            d.sub  = '0;
            d.line = 1'b1;
        end else if (q.st == FR_IDLE) begin
            d.line = 1'b1;
            if (wr_valid) begin
                d.sh   = wr_word;
                d.st   = FR_START;
                d.sub  = '0;
                d.idx  = '0;
                d.line = 1'b0;
            end
        end else if (tick) begin
            if (q.sub != OVS_W'(OVS - 1)) begin
                d.sub = q.sub + 1'b1;
            end else begin
                d.sub = '0;
                case (q.st)
                    FR_START: begin
                        d.st   = FR_DATA;
                        d.line = q.sh[0];
                    end
                    FR_DATA: begin
                        if (q.idx == IW'(DW - 1)) begin
                            if (nine) begin
                                d.st   = FR_NINTH;
                                d.line = q.sh[1];
                            end else begin
                                d.st   = FR_STOP;
                                d.line = 1'b1;
                            end
                        end else begin
                            d.idx  = q.idx + 1'b1;
                            d.sh   = q.sh >> 1;
                            d.line = q.sh[1];
                        end
                    end
                    FR_NINTH: begin
                        d.st   = FR_STOP;
                        d.line = 1'b1;
                    end
                    default: begin
                        d.st   = FR_IDLE;
                        d.line = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FR_IDLE, line: 1'b1, default: '0};
        else        q <= d;
    end

    assign wr_ready = en && (q.st == FR_IDLE);
    assign line     = q.line;
    assign busy     = (q.st != FR_IDLE);

endmodule

// File: rtl/uartl_rx.sv
module uartl_rx
    import uartl_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        tick,
    input  logic        nine,
    input  logic        din,
    output logic [DW:0] word,
    output logic        valid,
    output logic        ferr
);

    localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        frame_e           st;
        logic [OVS_W-1:0] sub;
        logic [IW-1:0]    idx;
        logic             prev;
        logic             sa;
        logic             sb;
        logic [DW-1:0]    sh;
        logic             b9;
        logic [DW:0]      word;
        logic             valid;
        logic             ferr;
    } rx_s;

    rx_s  q, d;
    logic maj;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.prev  = din;
        maj     = vote3(q.sa, q.sb, din);
        if (!en) begin
            d.st  = FR_IDLE;
            d.sub = '0;
        end else if (q.st == FR_IDLE) begin
            if (q.prev && !din) begin
                d.st  = FR_START;
                d.sub = '0;
                d.idx = '0;
            end
        end else if (tick) begin
            if (q.sub == OVS_W'(SMP_A)) d.sa = din;
            if (q.sub == OVS_W'(SMP_B)) d.sb = din;
            if (q.sub == OVS_W'(SMP_C)) begin
                case (q.st)
                    FR_START: if (maj) d.st = FR_IDLE;
                    FR_DATA:  d.sh = {maj, q.sh[DW-1:1]};
                    FR_NINTH: d.b9 = maj;
                    FR_STOP: begin
                        d.word  = {nine & q.b9, q.sh};
                        d.ferr  = !maj;
                        d.valid = 1'b1;
                        d.st    = FR_IDLE;
                    end
                    default: d.st = FR_IDLE;
                endcase
            end
            if (q.sub == OVS_W'(OVS - 1)) begin
                d.sub = '0;
                case (q.st)
                    FR_START: d.st = FR_DATA;
                    FR_DATA: begin
                        if (q.idx == IW'(DW - 1)) d.st = nine ? FR_NINTH : FR_STOP;
                        else                      d.idx = q.idx + 1'b1;
                    end
                    FR_NINTH: d.st = FR_STOP;
                    default:  d.st = FR_IDLE;
                endcase
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FR_IDLE, prev: 1'b1, default: '0};
        else        q <= d;
    end

    assign word  = q.word;
    assign valid = q.valid;
    assign ferr  = q.ferr;

endmodule

// File: rtl/uartl_top.sv
module uartl_top
    import uartl_pkg::*;
#(
    parameter int unsigned DIV_W = 13,
    parameter int unsigned DW    = 8,
    parameter int unsigned SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_loop,
    input  logic             cfg_src,
    input  logic             cfg_nine,
    input  logic [DW:0]      tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [DW:0]      rx_data,
    output logic             rx_valid,
    output logic             rx_ferr,
    input  logic             rxd_i,
    input  logic             txd_pad_i,
    output logic             txd_o,
    output logic             txd_oe
);

    typedef struct packed {
        logic [SYNC-1:0] sy;
    } top_s;

    top_s   q, d;
    route_e route;
    logic   en;
    logic   tick;
    logic   tx_line;
    logic   tx_busy;
    logic   rx_src;

    assign en = (cfg_div != '0);

    always_comb begin
        if (!cfg_loop)    route = RT_PINS;
        else if (cfg_src) route = RT_SHARED;
        else              route = RT_INTERNAL;
    end

    always_comb begin
        case (route)
            RT_INTERNAL: rx_src = tx_line;
            RT_SHARED:   rx_src = txd_pad_i;
            default:     rx_src = rxd_i;
        endcase
    end

    always_comb begin
        d    = q;
        d.sy = {q.sy[SYNC-2:0], rx_src};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    uartl_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (cfg_div),
        .tick  (tick)
    );

    uartl_tx #(.DW(DW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .nine     (cfg_nine),
        .wr_word  (tx_data),
        .wr_valid (tx_valid),
        .wr_ready (tx_ready),
        .line     (tx_line),
        .busy     (tx_busy)
    );

    uartl_rx #(.DW(DW)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .nine  (cfg_nine),
        .din   (q.sy[SYNC-1]),
        .word  (rx_data),
        .valid (rx_valid),
        .ferr  (rx_ferr)
    );

    assign txd_o  = en ? tx_line : 1'b1;
    assign txd_oe = (route == RT_SHARED) ? tx_busy : 1'b1;

endmodule

// File: rtl/uartl_chk.sv
module uartl_chk #(
    parameter int unsigned DIV_W = 13,
    parameter int unsigned DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] cfg_div,
    input logic             cfg_loop,
    input logic             cfg_src,
    input logic             cfg_nine,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [DW:0]      rx_data,
    input logic             rx_valid,
    input logic             txd_o,
    input logic             txd_oe
);

    assert_div0_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div == '0) |-> !tx_ready);

    assert_div0_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div == '0) |-> txd_o);

    assert_div0_norx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div == '0) |=> !rx_valid);

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd_o);

    assert_eight_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_nine) |-> !rx_data[DW]);

    // R5, R6, R8: the driver is always on unless the shared-wire route is selected
    assert_oe_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_loop && cfg_src) |-> txd_oe);

    assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_loop && cfg_src && tx_ready) |-> !txd_oe);

    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind uartl_top uartl_chk #(.DIV_W(DIV_W), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_div  (cfg_div),
    .cfg_loop (cfg_loop),
    .cfg_src  (cfg_src),
    .cfg_nine (cfg_nine),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .txd_o    (txd_o),
    .txd_oe   (txd_oe)
);

// File: tb/sim_uartl_top.sv
`timescale 1ns/1ps
module sim_uartl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_div;
    logic        cfg_loop, cfg_src, cfg_nine;
    logic [8:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic [8:0]  rx_data;
    logic        rx_valid, rx_ferr;
    logic        rxd_i, txd_pad_i, txd_o, txd_oe;
    logic        wire_back, rxd_drv, pad_ext;

    always #4 clk = ~clk;

    assign rxd_i     = wire_back ? txd_o : rxd_drv;
    assign txd_pad_i = txd_oe ? txd_o : pad_ext;

    uartl_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_loop(cfg_loop),
        .cfg_src(cfg_src), .cfg_nine(cfg_nine), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ferr(rx_ferr), .rxd_i(rxd_i),
        .txd_pad_i(txd_pad_i), .txd_o(txd_o), .txd_oe(txd_oe)
    );

    int          checks = 0;
    int          failures = 0;
    int          rx_seen = 0;
    logic [9:0]  exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected words as they come out
    logic       prev_v = 1'b0;
    logic [9:0] m_exp;
    string      m_tag;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v) chk(!rx_valid, "R12 strobe lasts one cycle", rx_valid, 0);
            if (rx_valid) begin
                rx_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R11 word not expected", {rx_ferr, rx_data}, 0);
                end else begin
                    m_exp = exp_q.pop_front();
                    m_tag = tag_q.pop_front();
                    chk({rx_ferr, rx_data} == m_exp, m_tag, {rx_ferr, rx_data}, m_exp);
                end
            end
            prev_v = rx_valid;
        end
    end

    task automatic expect_word(input logic [8:0] w, input logic fe, input string tag);
        exp_q.push_back({fe, w});
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [8:0] w, input string tag);
        while (!tx_ready) @(negedge clk);
        expect_word(cfg_nine ? w : {1'b0, w[7:0]}, 1'b0, tag);
        tx_data  = w;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(!tx_ready, "R10 ready low after accept", tx_ready, 0);
    endtask

    task automatic put_bit(input bit to_pad, input logic v, input int bt);
        if (to_pad) pad_ext = v;
        else        rxd_drv = v;
        repeat (bt) @(negedge clk);
    endtask

    task automatic drive_frame(input bit to_pad, input logic [8:0] w, input bit nine,
                               input bit stop, input int bt);
        put_bit(to_pad, 1'b0, bt);
        for (int i = 0; i < 8; i++) put_bit(to_pad, w[i], bt);
        if (nine) put_bit(to_pad, w[8], bt);
        put_bit(to_pad, stop, bt);
        put_bit(to_pad, 1'b1, 4);
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        repeat (64) @(negedge clk);
    endtask

    task automatic measure_low(output int n);
        send(9'h00F, "R1 pattern word returns");
        while (txd_o)  @(negedge clk);
        while (!txd_o) @(negedge clk);
        while (txd_o)  @(negedge clk);
        n = 0;
        while (!txd_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int  n, n0;
        bit  low_seen;
        cfg_div = 13'd2; cfg_loop = 1'b0; cfg_src = 1'b0; cfg_nine = 1'b0;
        tx_data = '0; tx_valid = 1'b0;
        wire_back = 1'b1; rxd_drv = 1'b1; pad_ext = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd_o == 1'b1, "R3 line idles high after reset", txd_o, 1);
        chk(tx_ready == 1'b1, "R10 ready after reset", tx_ready, 1);
        chk(txd_oe == 1'b1, "R5 driver on in two-pin mode", txd_oe, 1);
        chk(rx_valid == 1'b0, "R12 no strobe after reset", rx_valid, 0);

        // two-pin, 8-bit
        send(9'h1A5, "R3 8-bit frame drops bit 8");
        send(9'h03C, "R5 two-pin receive path");
        drain("R5 words drained");

        // bit timing
        cfg_div = 13'd3;
        measure_low(n);
        chk(n == 192, "R1 four bits at divisor 3", n, 192);
        drain("R1 divisor 3 drained");
        cfg_div = 13'd1;
        measure_low(n);
        chk(n == 64, "R1 four bits at divisor 1", n, 64);
        drain("R1 divisor 1 drained");
        cfg_div = 13'd2;

        // internal loop, 9-bit, RxD held low
        wire_back = 1'b0; rxd_drv = 1'b0;
        cfg_loop = 1'b1; cfg_src = 1'b0; cfg_nine = 1'b1;
        @(negedge clk);
        send(9'h1FF, "R4 ninth bit one via internal path");
        chk(txd_oe == 1'b1, "R6 driver on with internal path", txd_oe, 1);
        send(9'h100, "R4 only ninth bit set");
        send(9'h0AA, "R6 internal path ignores RxD");
        drain("R6 words drained");

        // shared wire
        cfg_src = 1'b1;
        @(negedge clk);
        chk(txd_oe == 1'b0, "R7 driver released while idle", txd_oe, 0);
        send(9'h155, "R7 shared wire echoes transmit");
        chk(txd_oe == 1'b1, "R7 driver on during frame", txd_oe, 1);
        drain("R7 echo drained");
        chk(txd_oe == 1'b0, "R7 driver released after frame", txd_oe, 0);
        expect_word(9'h0C3, 1'b0, "R7 external word on shared wire");
        drive_frame(1'b1, 9'h0C3, 1'b1, 1'b1, 32);
        drain("R7 external drained");

        // source select without loop
        rxd_drv = 1'b1;
        @(negedge clk);
        cfg_loop = 1'b0; cfg_src = 1'b1; cfg_nine = 1'b0;
        @(negedge clk);
        chk(txd_oe == 1'b1, "R8 select ignored, driver on", txd_oe, 1);
        expect_word(9'h05A, 1'b0, "R8 select ignored, RxD used");
        drive_frame(1'b0, 9'h05A, 1'b0, 1'b1, 32);
        drain("R8 drained");

        // framing
        expect_word(9'h081, 1'b1, "R9 low stop flagged");
        drive_frame(1'b0, 9'h081, 1'b0, 1'b0, 32);
        drain("R9 bad stop drained");
        expect_word(9'h07E, 1'b0, "R9 good stop clears flag");
        drive_frame(1'b0, 9'h07E, 1'b0, 1'b1, 32);
        drain("R9 good stop drained");

        // glitch
        n0 = rx_seen;
        rxd_drv = 1'b0;
        repeat (3) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (600) @(negedge clk);
        chk(rx_seen == n0, "R11 short low pulse rejected", rx_seen, n0);

        // divisor zero
        cfg_div = 13'd0;
        @(negedge clk);
        chk(tx_ready == 1'b0, "R2 ready low at divisor 0", tx_ready, 0);
        tx_data = 9'h000; tx_valid = 1'b1; low_seen = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (!txd_o) low_seen = 1'b1;
        end
        tx_valid = 1'b0;
        chk(!low_seen, "R2 line stays high at divisor 0", low_seen, 0);
        n0 = rx_seen;
        drive_frame(1'b0, 9'h033, 1'b0, 1'b1, 32);
        repeat (100) @(negedge clk);
        chk(rx_seen == n0, "R2 receiver silent at divisor 0", rx_seen, n0);
        wire_back = 1'b1;
        cfg_div = 13'd2;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R2 ready returns with divisor", tx_ready, 1);
        send(9'h066, "R2 operation resumes");
        drain("R2 resume drained");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule